// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a shared, fully associative translation buffer used by both the instruction and the data side of a processor. Each of its entries maps a pair of adjacent virtual pages (an even page and an odd page) tagged with an address-space identifier onto two physical frames in a 36-bit physical space. Each entry has its own page size, from 4 KB up to 16 MB in steps of four. Each page half carries its own frame number, a 3-bit cache-attribute code, a dirty bit and a valid bit.

A lookup port takes a 32-bit virtual address, an identifier and a load/store flag. One cycle later it returns exactly one of hit, miss, invalid or modified, together with the physical address and the attribute code. A management port writes entries at a given index or at a pseudo-random index, reads entries back, probes for a matching entry, and sets the page-size mask register and the count of locked low entries. Random writes never land in the locked region, so the operating system can keep chosen mappings resident.

Top module: `pair_tlb`

## Requirements
- R1: After synchronous reset no entry matches any lookup, the random index is 47, the locked count and page-mask register are 0, and the error flag, `lk_done` and `mg_done` are low.
- R2: Management op codes on `mg_op` are 0 none, 1 indexed write, 2 random write, 3 indexed read, 4 probe, 5 load page-mask register from `mg_mask`, 6 load locked count from `mg_index`. A write stores `mg_vpn2`, `mg_asid`, `mg_global`, `mg_lo`, `mg_hi` and the current page-mask register. An indexed read returns all of them on the `rd_*` outputs, and `mg_done` rises, one cycle after the op. Half words are laid out as frame in bits 28:5, attribute in bits 4:2, dirty in bit 1 and valid in bit 0.
- R3: A lookup matches an entry when the virtual page-pair number (address bits 31:13) agrees under the mask and either the identifiers are equal or the entry's global bit is set. The outcome appears with `lk_done` exactly one cycle after `lk_req`.
- R4: Within a matched entry, address bit 12+n, where n is the number of set mask bits, selects the odd half (1) or the even half (0). The physical address is the half's frame shifted left by 12, with its low 12+n bits taken from the virtual address.
- R5: Mask bit k removes address bit 13+k from the compare. Mask 0x000 gives 4 KB pages, 0x003 gives 16 KB pages, and so on up to 0xFFF, which gives 16 MB pages.
- R6: A lookup that matches an entry whose selected half has its valid bit clear reports `lk_invalid`.
- R7: A store lookup to a valid half whose dirty bit is clear reports `lk_modified`. A load to that half, or a store to a dirty half, reports `lk_hit`.
- R8: On a hit, `lk_attr` carries the half's attribute field unchanged.
- R9: Each clock the random index drops by one. When the current value is at or below the locked count, the next value is 47 instead.
- R10: Loading the locked count forces the random index to 47 on the next cycle. A random write stores at the random index present in the cycle of the op, so entries below the locked count are never replaced.
- R11: A probe compares `mg_vpn2` and `mg_asid` against all entries under the same rules as a lookup. It returns the index of a matching entry with `pr_fail` low, or sets `pr_fail` when nothing matches.
- R12: When a lookup or a probe matches more than one entry, the lowest index is used and `multi_err` is set. `multi_err` stays set until reset.
- R13: While `lk_done` is high exactly one of `lk_hit`, `lk_miss`, `lk_invalid` and `lk_modified` is high. While `lk_done` is low, none of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_store | input | 1 | Lookup is a store |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No entry matched |
| lk_invalid | output | 1 | Matched half not valid |
| lk_modified | output | 1 | Store to a clean half |
| lk_pa | output | 36 | Physical address |
| lk_attr | output | 3 | Cache-attribute code |
| mg_valid | input | 1 | Management op strobe |
| mg_op | input | 3 | Management op code |
| mg_index | input | 6 | Entry index or locked count |
| mg_vpn2 | input | 19 | Page-pair number for write or probe |
| mg_asid | input | 8 | Identifier for write or probe |
| mg_global | input | 1 | Global bit for write |
| mg_mask | input | 12 | Page-mask value |
| mg_lo | input | 29 | Even half for write |
| mg_hi | input | 29 | Odd half for write |
| mg_done | output | 1 | Management op completed |
| rd_vpn2 | output | 19 | Read page-pair number |
| rd_asid | output | 8 | Read identifier |
| rd_global | output | 1 | Read global bit |
| rd_mask | output | 12 | Read page mask |
| rd_lo | output | 29 | Read even half |
| rd_hi | output | 29 | Read odd half |
| pr_index | output | 6 | Probe result index |
| pr_fail | output | 1 | Probe found nothing |
| multi_err | output | 1 | Sticky multiple-match flag |
| rand_index | output | 6 | Current random replacement index |

## Verification
The bench goes after the selection of the half at the largest and a middle page size. A design that used a fixed bit 12 would hand back the wrong frame, and one that left the masked bits in the compare would miss the large pages. It also checks the identifier bypass of global entries, the priority of invalid over modified, and the wrap of the random index from the locked count back to 47. An off-by-one there would either replace a locked entry or skip the lowest free one. Finally it makes a duplicate mapping and checks that the lowest index wins and that the error flag stays set. A design that picked the highest index would return the other frame.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int unsigned VA_W     = 32;
    localparam int unsigned PA_W     = 36;
    localparam int unsigned ASID_W   = 8;
    localparam int unsigned MASK_W   = 12;
    localparam int unsigned ATTR_W   = 3;
    localparam int unsigned PG_SHIFT = 12;
    localparam int unsigned VPN2_W   = VA_W - PG_SHIFT - 1;
    localparam int unsigned PFN_W    = PA_W - PG_SHIFT;
    localparam int unsigned HALF_W   = PFN_W + ATTR_W + 2;
    localparam int unsigned DEF_ENTRIES = 48;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              dirty;
        logic              valid;
    } half_t;

    typedef struct packed {
        logic              live;
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic [MASK_W-1:0] mask;
        logic              glob;
        half_t             hi;
        half_t             lo;
    } entry_t;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_WR_IDX    = 3'd1,
        OP_WR_RAND   = 3'd2,
        OP_RD_IDX    = 3'd3,
        OP_PROBE     = 3'd4,
        OP_SET_MASK  = 3'd5,
        OP_SET_WIRED = 3'd6
    } mg_op_e;

    // Width of the page offset for a given mask; also the odd/even select bit.
    function automatic logic [4:0] offset_bits(input logic [MASK_W-1:0] m);
        return 5'(PG_SHIFT + $countones(m));
    endfunction

    function automatic logic [PA_W-1:0] offset_mask(input logic [MASK_W-1:0] m);
        return (PA_W'(1) << offset_bits(m)) - PA_W'(1);
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  entry_t            ent,
    input  logic [VPN2_W-1:0] vpn2,
    input  logic [ASID_W-1:0] asid,
    output logic              match
);
    logic [VPN2_W-1:0] care;
    logic              page_eq;
    logic              id_eq;

    always_comb begin
        care    = ~{{(VPN2_W-MASK_W){1'b0}}, ent.mask};
        page_eq = ((ent.vpn2 ^ vpn2) & care) == '0;
        id_eq   = ent.glob || (ent.asid == asid);
        match   = ent.live && page_eq && id_eq;
    end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int unsigned N     = 48,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any,
    output logic             multi
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
        multi = $countones(vec) > 1;
    end
endmodule

// File: rtl/tlb_rand.sv
module tlb_rand #(
    parameter int unsigned N     = 48,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_wired,
    input  logic [IDX_W-1:0] wired_d,
    output logic [IDX_W-1:0] idx_q,
    output logic [IDX_W-1:0] wired_q
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(N - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= TOP;
            wired_q <= '0;
        end else if (set_wired) begin
            wired_q <= wired_d;
            idx_q   <= TOP;
        end else if (idx_q <= wired_q) begin
            idx_q <= TOP;
        end else begin
            idx_q <= idx_q - 1'b1;
        end
    end
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
    import tlb_pkg::*;
#(
    parameter int unsigned N_ENT = DEF_ENTRIES,
    localparam int unsigned IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    output logic              lk_done,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_invalid,
    output logic              lk_modified,
    output logic [PA_W-1:0]   lk_pa,
    output logic [ATTR_W-1:0] lk_attr,
    input  logic              mg_valid,
    input  logic [2:0]        mg_op,
    input  logic [IDX_W-1:0]  mg_index,
    input  logic [VPN2_W-1:0] mg_vpn2,
    input  logic [ASID_W-1:0] mg_asid,
    input  logic              mg_global,
    input  logic [MASK_W-1:0] mg_mask,
    input  logic [HALF_W-1:0] mg_lo,
    input  logic [HALF_W-1:0] mg_hi,
    output logic              mg_done,
    output logic [VPN2_W-1:0] rd_vpn2,
    output logic [ASID_W-1:0] rd_asid,
    output logic              rd_global,
    output logic [MASK_W-1:0] rd_mask,
    output logic [HALF_W-1:0] rd_lo,
    output logic [HALF_W-1:0] rd_hi,
    output logic [IDX_W-1:0]  pr_index,
    output logic              pr_fail,
    output logic              multi_err,
    output logic [IDX_W-1:0]  rand_index
);
    entry_t            ents [N_ENT];
    logic [MASK_W-1:0] mask_q;
    logic [IDX_W-1:0]  wired_q;
    mg_op_e            op;

    logic [N_ENT-1:0]  lk_vec, pr_vec;
    logic [IDX_W-1:0]  lk_idx, pr_idx;
    logic              lk_any, lk_multi, pr_any, pr_multi;
    logic [VPN2_W-1:0] lk_vpn2;

    assign op      = mg_op_e'(mg_op);
    assign lk_vpn2 = lk_va[VA_W-1:PG_SHIFT+1];

    // Parallel compare arrays: one for lookups, one for probes.
    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        tlb_match u_lk (.ent(ents[e]), .vpn2(lk_vpn2), .asid(lk_asid), .match(lk_vec[e]));
        tlb_match u_pr (.ent(ents[e]), .vpn2(mg_vpn2), .asid(mg_asid), .match(pr_vec[e]));
    end

    tlb_pick #(.N(N_ENT), .IDX_W(IDX_W)) u_lk_pick (
        .vec(lk_vec), .idx(lk_idx), .any(lk_any), .multi(lk_multi));
    tlb_pick #(.N(N_ENT), .IDX_W(IDX_W)) u_pr_pick (
        .vec(pr_vec), .idx(pr_idx), .any(pr_any), .multi(pr_multi));

    tlb_rand #(.N(N_ENT), .IDX_W(IDX_W)) u_rand (
        .clk       (clk),
        .rst       (rst),
        .set_wired (mg_valid && (op == OP_SET_WIRED)),
        .wired_d   (mg_index),
        .idx_q     (rand_index),
        .wired_q   (wired_q)
    );

    // Lookup datapath: half select and physical address composition.
    entry_t          sel_ent;
    half_t           sel_half;
    logic            odd;
    logic [PA_W-1:0] offm, pa_c;
    logic            clean_store;

    always_comb begin
        sel_ent     = ents[lk_idx];
        odd         = lk_va[offset_bits(sel_ent.mask)];
        sel_half    = odd ? sel_ent.hi : sel_ent.lo;
        offm        = offset_mask(sel_ent.mask);
        pa_c        = ({sel_half.pfn, {PG_SHIFT{1'b0}}} & ~offm) | (PA_W'(lk_va) & offm);
        clean_store = lk_store && !sel_half.dirty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_done     <= 1'b0;
            lk_hit      <= 1'b0;
            lk_miss     <= 1'b0;
            lk_invalid  <= 1'b0;
            lk_modified <= 1'b0;
            lk_pa       <= '0;
            lk_attr     <= '0;
        end else begin
            lk_done     <= lk_req;
            lk_miss     <= lk_req && !lk_any;
            lk_invalid  <= lk_req && lk_any && !sel_half.valid;
            lk_modified <= lk_req && lk_any && sel_half.valid && clean_store;
            lk_hit      <= lk_req && lk_any && sel_half.valid && !clean_store;
            if (lk_req) begin
                lk_pa   <= pa_c;
                lk_attr <= sel_half.attr;
            end
        end
    end

    // Management port.
    entry_t           new_ent;
    logic [IDX_W-1:0] wr_idx;

    always_comb begin
        new_ent.live = 1'b1;
        new_ent.vpn2 = mg_vpn2;
        new_ent.asid = mg_asid;
        new_ent.mask = mask_q;
        new_ent.glob = mg_global;
        new_ent.lo   = half_t'(mg_lo);
        new_ent.hi   = half_t'(mg_hi);
        wr_idx       = (op == OP_WR_RAND) ? rand_index : mg_index;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < N_ENT; e++) ents[e] <= '0;
            mask_q    <= '0;
            mg_done   <= 1'b0;
            rd_vpn2   <= '0;
            rd_asid   <= '0;
            rd_global <= 1'b0;
            rd_mask   <= '0;
            rd_lo     <= '0;
            rd_hi     <= '0;
            pr_index  <= '0;
            pr_fail   <= 1'b0;
            multi_err <= 1'b0;
        end else begin
            mg_done <= mg_valid;
            if (mg_valid) begin
                case (op)
                    OP_WR_IDX, OP_WR_RAND: begin
                        if (32'(wr_idx) < N_ENT) ents[wr_idx] <= new_ent;
                    end
                    OP_RD_IDX: begin
                        if (32'(mg_index) < N_ENT) begin
                            rd_vpn2   <= ents[mg_index].vpn2;
                            rd_asid   <= ents[mg_index].asid;
                            rd_global <= ents[mg_index].glob;
                            rd_mask   <= ents[mg_index].mask;
                            rd_lo     <= ents[mg_index].lo;
                            rd_hi     <= ents[mg_index].hi;
                        end
                    end
                    OP_PROBE: begin
                        pr_fail <= !pr_any;
                        if (pr_any) pr_index <= pr_idx;
                        if (pr_multi) multi_err <= 1'b1;
                    end
                    OP_SET_MASK: mask_q <= mg_mask;
                    default: ;
                endcase
            end
            if (lk_req && lk_multi) multi_err <= 1'b1;
        end
    end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
    import tlb_pkg::*;
#(
    parameter int unsigned N_ENT = DEF_ENTRIES,
    localparam int unsigned IDX_W = $clog2(N_ENT)
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_req,
    input logic             lk_done,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_invalid,
    input logic             lk_modified,
    input logic             mg_valid,
    input logic [2:0]       mg_op,
    input logic             mg_done,
    input logic             multi_err,
    input logic [IDX_W-1:0] rand_index,
    input logic [IDX_W-1:0] wired_q
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(N_ENT - 1);

    a_r13_one_outcome: assert property (@(posedge clk) disable iff (rst)
        lk_done |-> $onehot({lk_hit, lk_miss, lk_invalid, lk_modified}));

    a_r13_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !lk_done |-> ({lk_hit, lk_miss, lk_invalid, lk_modified} == 4'b0));

    a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> lk_done);

    a_r9_step_down: assert property (@(posedge clk) disable iff (rst)
        (!(mg_valid && mg_op == 3'(OP_SET_WIRED)) && rand_index > wired_q)
        |=> rand_index == $past(rand_index) - 1'b1);

    a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
        (rand_index <= wired_q) |=> rand_index == TOP);

    a_r10_force_top: assert property (@(posedge clk) disable iff (rst)
        (mg_valid && mg_op == 3'(OP_SET_WIRED)) |=> rand_index == TOP);

    a_r12_sticky: assert property (@(posedge clk) disable iff (rst)
        multi_err |=> multi_err);

    a_r2_done: assert property (@(posedge clk) disable iff (rst)
        mg_valid |=> mg_done);
endmodule

bind pair_tlb tlb_checker #(.N_ENT(N_ENT)) u_tlb_checker (
    .clk         (clk),
    .rst         (rst),
    .lk_req      (lk_req),
    .lk_done     (lk_done),
    .lk_hit      (lk_hit),
    .lk_miss     (lk_miss),
    .lk_invalid  (lk_invalid),
    .lk_modified (lk_modified),
    .mg_valid    (mg_valid),
    .mg_op       (mg_op),
    .mg_done     (mg_done),
    .multi_err   (multi_err),
    .rand_index  (rand_index),
    .wired_q     (wired_q)
);

// File: tb/test_pair_tlb.sv
`timescale 1ns/1ps
module test_pair_tlb;
    import tlb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              lk_req = 0, lk_store = 0;
    logic [31:0]       lk_va = '0;
    logic [7:0]        lk_asid = '0;
    logic              lk_done, lk_hit, lk_miss, lk_invalid, lk_modified;
    logic [35:0]       lk_pa;
    logic [2:0]        lk_attr;
    logic              mg_valid = 0, mg_global = 0;
    logic [2:0]        mg_op = '0;
    logic [5:0]        mg_index = '0;
    logic [18:0]       mg_vpn2 = '0;
    logic [7:0]        mg_asid = '0;
    logic [11:0]       mg_mask = '0;
    logic [28:0]       mg_lo = '0, mg_hi = '0;
    logic              mg_done, rd_global, pr_fail, multi_err;
    logic [18:0]       rd_vpn2;
    logic [7:0]        rd_asid;
    logic [11:0]       rd_mask;
    logic [28:0]       rd_lo, rd_hi;
    logic [5:0]        pr_index, rand_index;

    pair_tlb i_pair_tlb (.*);

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [3:0]  flags;   // {hit, miss, invalid, modified}
        logic [35:0] pa;
        logic [2:0]  attr;
        string       req;
    } exp_t;
    exp_t sb[$];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [28:0] half(input logic [23:0] pfn, input logic [2:0] attr,
                                         input logic d, input logic v);
        return {pfn, attr, d, v};
    endfunction

    function automatic logic [18:0] vp(input logic [31:0] va);
        return va[31:13];
    endfunction

    task automatic mg(input logic [2:0] op, input logic [5:0] idx, input logic [31:0] va,
                      input logic [7:0] asid, input logic g, input logic [11:0] m,
                      input logic [28:0] lo, input logic [28:0] hi);
        @(negedge clk);
        mg_valid = 1; mg_op = op; mg_index = idx; mg_vpn2 = vp(va);
        mg_asid = asid; mg_global = g; mg_mask = m; mg_lo = lo; mg_hi = hi;
        @(negedge clk);
        mg_valid = 0; mg_op = 3'd0;
    endtask

    // Driver: pushes the expected outcome, then presents the request for one cycle.
    task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic st,
                        input logic [3:0] flags, input logic [35:0] pa, input logic [2:0] attr,
                        input string req);
        exp_t e;
        @(negedge clk);
        e.flags = flags; e.pa = pa; e.attr = attr; e.req = req;
        sb.push_back(e);
        lk_req = 1; lk_va = va; lk_asid = asid; lk_store = st;
        @(negedge clk);
        lk_req = 0; lk_store = 0;
    endtask

    // Monitor: pops an expected item for every completed lookup.
    always @(negedge clk) begin
        if (!rst && lk_done) begin
            if (sb.size() == 0) begin
                check(0, "R3 unexpected result", 64'(lk_done), 64'(0));
            end else begin
                exp_t e;
                logic [3:0] got;
                e = sb.pop_front();
                got = {lk_hit, lk_miss, lk_invalid, lk_modified};
                check(got == e.flags, e.req, 64'(got), 64'(e.flags));
                if (e.flags == 4'b1000) begin
                    check(lk_pa == e.pa, {e.req, " pa"}, 64'(lk_pa), 64'(e.pa));
                    check(lk_attr == e.attr, {e.req, " R8 attr"}, 64'(lk_attr), 64'(e.attr));
                end
            end
        end
    end

    localparam logic [3:0] HIT = 4'b1000, MISS = 4'b0100, INV = 4'b0010, MOD = 4'b0001;

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [5:0] r;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check(rand_index == 6'd47, "R1 random index", 64'(rand_index), 64'd47);
        check(!multi_err && !mg_done && !lk_done, "R1 flags low",
              64'({multi_err, mg_done, lk_done}), 64'd0);
        look(32'h0000_1000, 8'd1, 0, MISS, '0, '0, "R1 lookup after reset");
        look(32'h0000_0000, 8'd0, 0, MISS, '0, '0, "R1 zero address after reset");

        // 4 KB pair at index 5
        mg(3'd5, 0, 0, 0, 0, 12'h000, 0, 0);
        mg(3'd1, 6'd5, 32'h4000_0000, 8'd7, 0, 0,
           half(24'h0000AB, 3'd3, 1, 1), half(24'h00F0CD, 3'd2, 0, 1));
        mg(3'd3, 6'd5, 0, 0, 0, 0, 0, 0);
        check(mg_done, "R2 done", 64'(mg_done), 64'd1);
        check(rd_vpn2 == vp(32'h4000_0000) && rd_asid == 8'd7 && !rd_global && rd_mask == 0,
              "R2 read tag", 64'({rd_vpn2, rd_asid, rd_global, rd_mask}),
              64'({vp(32'h4000_0000), 8'd7, 1'b0, 12'h000}));
        check(rd_lo == half(24'h0000AB, 3'd3, 1, 1) && rd_hi == half(24'h00F0CD, 3'd2, 0, 1),
              "R2 read halves", 64'({rd_lo, rd_hi}),
              64'({half(24'h0000AB, 3'd3, 1, 1), half(24'h00F0CD, 3'd2, 0, 1)}));
        look(32'h4000_0123, 8'd7, 0, HIT, 36'h0000AB123, 3'd3, "R4 even half 4K");
        look(32'h4000_1456, 8'd7, 0, HIT, 36'h00F0CD456, 3'd2, "R4 odd half 4K");
        look(32'h4000_1456, 8'd7, 1, MOD, '0, '0, "R7 store to clean half");
        look(32'h4000_0123, 8'd7, 1, HIT, 36'h0000AB123, 3'd3, "R7 store to dirty half");
        look(32'h4000_0123, 8'd8, 0, MISS, '0, '0, "R3 identifier mismatch");
        look(32'h4000_2000, 8'd7, 0, MISS, '0, '0, "R3 page mismatch");

        // global entry with an invalid even half
        mg(3'd1, 6'd6, 32'h5000_0000, 8'd1, 1, 0,
           half(24'h000555, 3'd1, 1, 0), half(24'h000777, 3'd0, 1, 1));
        look(32'h5000_0010, 8'h55, 1, INV, '0, '0, "R6 invalid half beats store");
        look(32'h5000_1010, 8'h55, 0, HIT, 36'h000777010, 3'd0, "R3 global ignores identifier");

        // 16 MB pair at index 9
        mg(3'd5, 0, 0, 0, 0, 12'hFFF, 0, 0);
        mg(3'd1, 6'd9, 32'h0600_0000, 8'd2, 0, 0,
           half(24'h00A000, 3'd5, 1, 1), half(24'h00B000, 3'd6, 1, 1));
        mg(3'd3, 6'd9, 0, 0, 0, 0, 0, 0);
        check(rd_mask == 12'hFFF, "R2 mask captured", 64'(rd_mask), 64'hFFF);
        look(32'h06AB_CDEF, 8'd2, 0, HIT, 36'h00AABCDEF, 3'd5, "R5 16M even");
        look(32'h0712_3456, 8'd2, 0, HIT, 36'h00B123456, 3'd6, "R5 16M odd");

        // 16 KB pair at index 10
        mg(3'd5, 0, 0, 0, 0, 12'h003, 0, 0);
        mg(3'd1, 6'd10, 32'h3000_0000, 8'd2, 0, 0,
           half(24'h000040, 3'd1, 1, 1), half(24'h000080, 3'd4, 1, 1));
        look(32'h3000_2ABC, 8'd2, 0, HIT, 36'h000042ABC, 3'd1, "R5 16K even");
        look(32'h3000_5000, 8'd2, 0, HIT, 36'h000081000, 3'd4, "R4 16K odd");
        look(32'h3000_8000, 8'd2, 0, MISS, '0, '0, "R5 16K outside pair");

        // probes
        mg(3'd4, 0, 32'h4000_0000, 8'd7, 0, 0, 0, 0);
        check(!pr_fail && pr_index == 6'd5, "R11 probe hit", 64'({pr_fail, pr_index}), 64'd5);
        mg(3'd4, 0, 32'h0700_0000, 8'd2, 0, 0, 0, 0);
        check(!pr_fail && pr_index == 6'd9, "R11 probe masked", 64'({pr_fail, pr_index}), 64'd9);
        mg(3'd4, 0, 32'h7000_0000, 8'd7, 0, 0, 0, 0);
        check(pr_fail, "R11 probe fail", 64'(pr_fail), 64'd1);
        check(!multi_err, "R12 no error yet", 64'(multi_err), 64'd0);

        // duplicate mapping
        mg(3'd5, 0, 0, 0, 0, 12'h000, 0, 0);
        mg(3'd1, 6'd20, 32'h4000_0000, 8'd7, 0, 0,
           half(24'h000FFF, 3'd7, 1, 1), half(24'h000FFE, 3'd7, 1, 1));
        look(32'h4000_0123, 8'd7, 0, HIT, 36'h0000AB123, 3'd3, "R12 lowest index wins");
        check(multi_err, "R12 error set", 64'(multi_err), 64'd1);
        mg(3'd0, 0, 0, 0, 0, 0, 0, 0);
        check(multi_err, "R12 error sticky", 64'(multi_err), 64'd1);

        // random index and locked region
        mg(3'd6, 6'd8, 0, 0, 0, 0, 0, 0);
        check(rand_index == 6'd47, "R10 forced to 47", 64'(rand_index), 64'd47);
        repeat (39) @(negedge clk);
        check(rand_index == 6'd8, "R9 reaches locked count", 64'(rand_index), 64'd8);
        @(negedge clk);
        check(rand_index == 6'd47, "R9 wraps to 47", 64'(rand_index), 64'd47);
        repeat (5) @(negedge clk);
        check(rand_index == 6'd42, "R9 counts down", 64'(rand_index), 64'd42);

        for (int k = 0; k < 3; k++) begin
            logic [31:0] va;
            va = 32'h6000_0000 + 32'(k) * 32'h8000;
            @(negedge clk);
            r = rand_index;
            mg_valid = 1; mg_op = 3'd2; mg_vpn2 = vp(va); mg_asid = 8'd3;
            mg_global = 0; mg_lo = half(24'h000100, 3'd0, 1, 1); mg_hi = '0;
            @(negedge clk);
            mg_valid = 0; mg_op = 3'd0;
            check(r >= 6'd8, "R10 random index above locked", 64'(r), 64'd8);
            mg(3'd3, r, 0, 0, 0, 0, 0, 0);
            check(rd_vpn2 == vp(va), "R10 random write landed", 64'(rd_vpn2), 64'(vp(va)));
        end

        mg(3'd6, 6'd40, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 12; k++)
            mg(3'd2, 0, 32'h7800_0000, 8'd9, 0, 0, half(24'h000200, 3'd0, 1, 1), 0);
        mg(3'd3, 6'd5, 0, 0, 0, 0, 0, 0);
        check(rd_vpn2 == vp(32'h4000_0000), "R10 locked entry kept", 64'(rd_vpn2),
              64'(vp(32'h4000_0000)));
        mg(3'd3, 6'd20, 0, 0, 0, 0, 0, 0);
        check(rd_lo == half(24'h000FFF, 3'd7, 1, 1), "R10 locked entry 20 kept", 64'(rd_lo),
              64'(half(24'h000FFF, 3'd7, 1, 1)));

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R3 all lookups answered", 64'(sb.size()), 64'd0);
        summary();
    end
endmodule